// File: doc/BRIEF.md
# Receive FIFO DMA Start Controller

This block sits between a receive FIFO and a bus-master DMA engine. It watches how many bytes of the packet now arriving are held in the FIFO. It also watches whether the FIFO already holds the end of that packet. From these it decides when the engine may begin copying the packet to host memory. A 3-bit threshold code picks a byte level, from 16 to 1024 bytes in doubling steps. Reaching that level starts the packet early, before it has fully arrived. A complete packet in the FIFO always starts at once, and one code value turns the byte level off so that only complete packets start.

Each transfer is cut into bursts. A second 3-bit code sets a power-of-two cap on the burst length, and one code value removes the cap. Each burst is as long as the cap allows, but no longer than the bytes the FIFO holds at that moment. When the packet is complete, the FIFO count is also the number of bytes left in the packet. After the first burst of a packet, further bursts follow whenever bytes are waiting, and the threshold is not checked again. This goes on until the packet's last byte has left the FIFO. Both codes are taken when a packet starts, so a change made while a packet is moving applies from the next packet.

Each burst goes to the engine as a level request with a length, and the engine answers with a one-cycle acknowledge. After the handshake the engine removes that many bytes from the FIFO count.

Top module: `rx_dma_start_ctrl`

## Requirements
- R1: While idle, with a threshold code c from 0 to 6, a buffered count of at least 16·2^c bytes raises `dma_req` on the next clock edge. A count below that level, with the packet incomplete, leaves `dma_req` low.
- R2: With threshold code 7, an incomplete packet never raises `dma_req`, whatever its buffered count.
- R3: While idle, `pkt_done` high with a nonzero count raises `dma_req` on the next edge, whatever the threshold code.
- R4: Burst code b from 0 to 6 caps `dma_len` at 16·2^b bytes. Burst code 7 leaves it uncapped.
- R5: When `dma_req` rises, `dma_len` equals the smaller of the cap and the count presented on the previous cycle, and is never zero.
- R6: After a packet has started, every cycle spent between bursts with a nonzero count leads to a new request on the next edge. `pkt_done` high with a zero count returns the block to idle with no request.
- R7: The burst code is captured when a packet starts. Changes to either code during the packet do not alter its burst lengths.
- R8: `dma_req` and `dma_len` hold steady until `dma_ack` is seen. `dma_req` is low in the cycle after the acknowledge, so each burst is requested once.
- R9: After reset, `dma_req` is low and `dma_len` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_code | input | 3 | Start threshold code; 7 means complete packets only |
| burst_code | input | 3 | Burst length cap code; 7 means no cap |
| fifo_bytes | input | CNT_W | Bytes of the current packet held in the FIFO, not yet moved |
| pkt_done | input | 1 | The FIFO holds the last byte of the current packet |
| dma_ack | input | 1 | One-cycle acknowledge from the DMA engine |
| dma_req | output | 1 | Burst request, held until acknowledged |
| dma_len | output | CNT_W | Length in bytes of the requested burst |

## Verification
The bench builds the block with a 12-bit byte count. That width is enough for packets up to 1800 bytes, so every threshold and every burst cap, including the 1024-byte steps, can be hit exactly and passed. A count that lands exactly on the threshold is covered, as is a one-byte packet and a packet that finishes below a 1024-byte threshold. The bench also covers uncapped bursts that carry a whole packet, codes changed in the middle of a packet, and acknowledges held back for random spans. Together these reach every branch of the start decision and of the burst sizing.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_REQ    = 2'd2
  } rxdma_state_e;

  localparam logic [2:0] CODE_OPEN = 3'b111;

  // Byte level encoded by a 3-bit code below CODE_OPEN.
  function automatic logic [31:0] code_bytes(input logic [2:0] code);
    return 32'd16 << code;
  endfunction

endpackage

// File: rtl/rxdma_start_eval.sv
module rxdma_start_eval #(
  parameter int CNT_W = 16
) (
  input  logic [2:0]       thr_code,
  input  logic [CNT_W-1:0] fifo_bytes,
  input  logic             pkt_done,
  output logic             thr_hit,
  output logic             whole_pkt,
  output logic             start_ok
);
  import rxdma_pkg::*;

  logic [31:0] cnt_ext;

  always_comb begin
    cnt_ext   = 32'(fifo_bytes);
    thr_hit   = (thr_code != CODE_OPEN) && (cnt_ext >= code_bytes(thr_code));
    whole_pkt = pkt_done && (fifo_bytes != '0);
    start_ok  = thr_hit || whole_pkt;
  end

endmodule

// File: rtl/rxdma_burst_size.sv
module rxdma_burst_size #(
  parameter int CNT_W = 16
) (
  input  logic [2:0]       burst_code,
  input  logic [CNT_W-1:0] fifo_bytes,
  output logic [31:0]      burst_cap,
  output logic [CNT_W-1:0] burst_len
);
  import rxdma_pkg::*;

  logic [31:0] cnt_ext;

  always_comb begin
    cnt_ext   = 32'(fifo_bytes);
    burst_cap = (burst_code == CODE_OPEN) ? 32'hFFFF_FFFF : code_bytes(burst_code);
    burst_len = (cnt_ext <= burst_cap) ? fifo_bytes : burst_cap[CNT_W-1:0];
  end

endmodule

// File: rtl/rx_dma_start_ctrl.sv
module rx_dma_start_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       thr_code,
  input  logic [2:0]       burst_code,
  input  logic [CNT_W-1:0] fifo_bytes,
  input  logic             pkt_done,
  input  logic             dma_ack,
  output logic             dma_req,
  output logic [CNT_W-1:0] dma_len
);
  import rxdma_pkg::*;

  rxdma_state_e     state_q;
  logic [2:0]       bcode_q;
  logic [2:0]       bcode_sel;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_c;
  logic [31:0]      burst_cap;
  logic             thr_hit, whole_pkt, start_ok;

  // Named events for the checker.
  logic in_idle, in_active, pkt_start, burst_issue, pkt_end;

  rxdma_start_eval #(.CNT_W(CNT_W)) u_eval (
    .thr_code  (thr_code),
    .fifo_bytes(fifo_bytes),
    .pkt_done  (pkt_done),
    .thr_hit   (thr_hit),
    .whole_pkt (whole_pkt),
    .start_ok  (start_ok)
  );

  // Live code while idle; captured code once a packet runs.
  assign bcode_sel = (state_q == ST_IDLE) ? burst_code : bcode_q;

  rxdma_burst_size #(.CNT_W(CNT_W)) u_size (
    .burst_code(bcode_sel),
    .fifo_bytes(fifo_bytes),
    .burst_cap (burst_cap),
    .burst_len (len_c)
  );

  always_comb begin
    in_idle     = (state_q == ST_IDLE);
    in_active   = (state_q == ST_ACTIVE);
    pkt_start   = in_idle && start_ok;
    pkt_end     = in_active && pkt_done && (fifo_bytes == '0);
    burst_issue = pkt_start || (in_active && !pkt_done && (fifo_bytes != '0))
                            || (in_active && pkt_done && (fifo_bytes != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcode_q <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pkt_start) begin
            bcode_q <= burst_code;
            len_q   <= len_c;
            state_q <= ST_REQ;
          end
        end
        ST_ACTIVE: begin
          if (pkt_end) begin
            state_q <= ST_IDLE;
          end else if (burst_issue) begin
            len_q   <= len_c;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (dma_ack) state_q <= ST_ACTIVE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dma_req = (state_q == ST_REQ);
  assign dma_len = len_q;

endmodule

// File: rtl/rx_dma_start_chk.sv
module rx_dma_start_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       thr_code,
  input logic [CNT_W-1:0] fifo_bytes,
  input logic             pkt_done,
  input logic             dma_ack,
  input logic             dma_req,
  input logic [CNT_W-1:0] dma_len,
  input logic             in_idle,
  input logic             in_active,
  input logic [2:0]       bcode_q,
  input logic [31:0]      burst_cap
);

  p_thr_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && thr_code != 3'd7 && 32'(fifo_bytes) >= (32'd16 << thr_code) |=> dma_req);

  p_store_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && thr_code == 3'd7 && !pkt_done |=> !dma_req);

  p_whole_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && pkt_done && fifo_bytes != '0 |=> dma_req);

  p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> 32'(dma_len) <= burst_cap);

  p_len_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> dma_len != '0 && dma_len <= $past(fifo_bytes));

  p_continue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_active && fifo_bytes != '0 |=> dma_req);

  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_active && pkt_done && fifo_bytes == '0 |=> in_idle && !dma_req);

  p_code_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle |=> $stable(bcode_q));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack |=> dma_req && $stable(dma_len));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_ack |=> !dma_req);

endmodule

bind rx_dma_start_ctrl rx_dma_start_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .thr_code  (thr_code),
  .fifo_bytes(fifo_bytes),
  .pkt_done  (pkt_done),
  .dma_ack   (dma_ack),
  .dma_req   (dma_req),
  .dma_len   (dma_len),
  .in_idle   (in_idle),
  .in_active (in_active),
  .bcode_q   (bcode_q),
  .burst_cap (burst_cap)
);

// File: tb/sim_rx_dma_start_ctrl.sv
module sim_rx_dma_start_ctrl;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       thr_code = '0;
  logic [2:0]       burst_code = '0;
  logic [CNT_W-1:0] fifo_bytes = '0;
  logic             pkt_done = 1'b0;
  logic             dma_ack = 1'b0;
  logic             dma_req;
  logic [CNT_W-1:0] dma_len;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_dma_start_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .thr_code(thr_code), .burst_code(burst_code),
    .fifo_bytes(fifo_bytes), .pkt_done(pkt_done), .dma_ack(dma_ack),
    .dma_req(dma_req), .dma_len(dma_len)
  );

  function automatic int level_of(int code);
    if (code == 7) return -1;
    return 16 * (2 ** code);
  endfunction

  function automatic int want_len(int code, int avail);
    if (code == 7) return avail;
    return (avail < 16 * (2 ** code)) ? avail : 16 * (2 ** code);
  endfunction

  function automatic bit want_start(int code, int avail, bit done);
    if (done && avail > 0) return 1'b1;
    if (code == 7) return 1'b0;
    return avail >= level_of(code);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_packet(int plen, int thr_c, int bc_c, int rate, bit flip);
    int  fifo = 0;
    int  recv = 0;
    bit  done = 1'b0;
    bit  started = 1'b0;
    bit  prev_req = 1'b0;
    bit  ack_d = 1'b0;
    bit  finished = 1'b0;
    int  held_len = 0;
    int  bc_pkt = bc_c;
    int  guard = 0;
    thr_code   = 3'(thr_c);
    burst_code = 3'(bc_c);
    fifo_bytes = '0;
    pkt_done   = 1'b0;
    dma_ack    = 1'b0;
    while (!finished && guard < 20000) begin
      bit r;
      int l;
      @(negedge clk);
      guard++;
      r = dma_req;
      l = int'(dma_len);
      if (prev_req && ack_d) begin
        check(r == 1'b0, "R8 drop after ack", r, 0);
        fifo -= held_len;
        ack_d = 1'b0;
      end else if (prev_req) begin
        check(r == 1'b1 && l == held_len, "R8 hold until ack", l, held_len);
      end else begin
        if (!started) begin
          bit e = want_start(int'(thr_code), fifo, done);
          string tg = (done && fifo > 0) ? "R3 start on whole packet" :
                      (thr_code == 3'd7) ? "R2 no early start" : "R1 threshold start";
          check(r == e, tg, r, e);
        end else if (done && fifo == 0) begin
          check(r == 1'b0, "R6 return to idle", r, 0);
          finished = 1'b1;
        end else begin
          check(r == (fifo > 0), "R6 continue bursts", r, fifo > 0);
        end
        if (r) begin
          int e;
          if (!started) begin
            started = 1'b1;
            bc_pkt  = int'(burst_code);
          end
          e = want_len(bc_pkt, fifo);
          check(l == e, flip ? "R7 captured burst code" :
                        (bc_pkt == 7) ? "R4 R5 uncapped length" : "R4 R5 burst length", l, e);
          held_len = l;
        end
      end
      prev_req = r;
      if (r && !ack_d) ack_d = ($urandom % 2) == 0;
      dma_ack = ack_d;
      if (!done && !finished) begin
        int add = int'($urandom % (rate + 1));
        if (add > plen - recv) add = plen - recv;
        recv += add;
        fifo += add;
        if (recv == plen) done = 1'b1;
      end
      if (flip && started) begin
        thr_code   = 3'($urandom);
        burst_code = 3'($urandom);
      end
      fifo_bytes = CNT_W'(fifo);
      pkt_done   = done;
    end
    if (!finished) check(1'b0, "R6 packet did not finish", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(dma_req == 1'b0 && dma_len == '0, "R9 reset state", int'(dma_len), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dma_req == 1'b0, "R9 idle after reset", dma_req, 0);
    run_packet(100, 0, 0, 3, 1'b0);     // exact 16-byte level, 16-byte bursts
    run_packet(300, 7, 7, 20, 1'b0);    // complete packet only, one uncapped burst
    run_packet(200, 6, 3, 16, 1'b0);    // packet ends below 1024-byte level
    run_packet(1000, 3, 2, 32, 1'b0);   // 128-byte level, 64-byte cap
    run_packet(1500, 1, 5, 40, 1'b1);   // codes changed mid packet
    run_packet(1, 0, 6, 1, 1'b0);       // one-byte packet
    run_packet(1800, 6, 6, 48, 1'b0);   // 1024-byte level and cap
    for (int i = 0; i < 40; i++) begin
      run_packet(1 + int'($urandom % 1800), int'($urandom % 8), int'($urandom % 8),
                 1 + int'($urandom % 48), ($urandom % 4) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule